// File: doc/BRIEF.md
# Scratchpad Bank Conflict Monitor

This block watches the request stream of a 32-lane banked scratchpad and works out how many cycles each request will keep the banks busy. Every 4-byte word sits in bank `(byte_address >> 2) mod 32`. A bank can deliver one word per cycle, so a request costs as many cycles as the largest number of distinct words that any one bank has to supply. Lanes that name the same word share a single access. A request that every lane aims at one address therefore costs one cycle, and that is not counted as a conflict. The monitor only observes the traffic and never touches the memory.

Each accepted request gives a registered result one cycle later, and the monitor can take a new request every cycle. Four saturating counters collect profiling data: non-empty requests, total bank cycles, extra cycles lost on loads, and extra cycles lost on stores. Software divides the conflict tallies by the request or cycle totals to get a conflict ratio. A small select port reads any one counter at a time, and a synchronous clear input zeroes all four.

The result stage is a two-state machine. `ST_IDLE` means no result is on the output. `ST_REPORT` means a result is on the output this cycle. In either state, an incoming request moves it to `ST_REPORT`, and a cycle with no request moves it to `ST_IDLE`.

Top module: `smem_bank_monitor`

## Requirements
- R1: For a request sampled with `req_valid`=1, `res_cycles` one clock later equals the maximum, over all banks, of the number of distinct word addresses (byte address >> 2) among the valid lanes mapped to that bank. The bank is word address mod 32. Byte offsets inside a word do not matter.
- R2: Valid lanes that name the same word count once. A request where every valid lane uses one identical address gives `res_cycles`=1.
- R3: A request with an all-zero lane mask gives `res_cycles`=0 and changes no counter.
- R4: With all 32 lanes valid and lane i at word address base+i×s, the result is 1 for s=1, 2 for s=2 and 32 for s=32.
- R5: Counter select 0 counts requests with at least one valid lane. Counter select 1 sums their `res_cycles`. Each counter updates on the clock edge after the one that registered the result.
- R6: For each non-empty request, `res_cycles`−1 is added to counter select 2 when `req_is_store`=0, or to counter select 3 when `req_is_store`=1. The other conflict counter stays unchanged.
- R7: Every counter is `CNT_W` bits wide (default 32) and holds at all ones instead of wrapping.
- R8: `clr`=1 at a clock edge sets all four counters to zero at that edge. This takes priority over any increment due at the same edge.
- R9: `rd_data` combinationally shows the counter chosen by `rd_sel` (0 requests, 1 total cycles, 2 load conflicts, 3 store conflicts).
- R10: While `rst_n`=0, `res_valid` is 0 and every counter reads 0.
- R11: A request can arrive every cycle. `res_valid` is 1 exactly in the cycle after each sampled request and 0 after a cycle without one, and `res_is_store` repeats the request's store flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_store | input | 1 | 1 for a store request, 0 for a load |
| req_lane_mask | input | LANES | Per-lane valid bits |
| req_addr | input | LANES*ADDR_W | Byte address of lane i at bits [i*ADDR_W +: ADDR_W] |
| res_valid | output | 1 | Result of the previous cycle's request |
| res_cycles | output | $clog2(LANES+1) | Serialized bank cycles for that request |
| res_is_store | output | 1 | Store flag of that request |
| rd_sel | input | 2 | Counter select for the read port |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
The bench builds two copies that receive the same stimulus. One uses the defaults (32 lanes, 32 banks, 16-bit byte addresses, 32-bit counters). The other shrinks the counters to 6 bits, so saturation at 63 shows up after only a few high-conflict requests, which the 32-bit copy could never reach in a short run. With 16-bit addresses, the random strides and dense address windows wrap around the bank set, so they produce many merged lanes and partial conflicts alongside the directed stride and broadcast cases.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int NUM_CNT = 4;

    typedef enum logic [1:0] {
        SEL_REQS    = 2'd0,
        SEL_CYCLES  = 2'd1,
        SEL_LD_CONF = 2'd2,
        SEL_ST_CONF = 2'd3
    } cnt_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } mon_state_e;

endpackage

// File: rtl/sbm_word_dedup.sv
module sbm_word_dedup #(
    parameter int LANES   = 32,
    parameter int WADDR_W = 14
) (
    input  logic [LANES-1:0]              lane_mask,
    input  logic [LANES-1:0][WADDR_W-1:0] word_addr,
    output logic [LANES-1:0]              lane_first
);

    // A lane is the representative of its word when no lower valid lane
    // names the same word; later duplicates ride along for free.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_first[i] = lane_mask[i];
            for (int j = 0; j < LANES; j++) begin
                if ((j < i) && lane_mask[j] && (word_addr[j] == word_addr[i])) begin
                    lane_first[i] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sbm_bank_histogram.sv
module sbm_bank_histogram #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int BANK_W = 5,
    parameter int CYC_W  = 6
) (
    input  logic [LANES-1:0]             lane_first,
    input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
    output logic [CYC_W-1:0]             max_depth
);

    logic [BANKS-1:0][CYC_W-1:0] bank_depth;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb begin
            bank_depth[b] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (lane_first[l] && (lane_bank[l] == BANK_W'(b))) begin
                    bank_depth[b] = bank_depth[b] + CYC_W'(1);
                end
            end
        end
    end

    always_comb begin
        max_depth = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_depth[b] > max_depth) begin
                max_depth = bank_depth[b];
            end
        end
    end

endmodule

// File: rtl/sbm_sat_counter.sv
module sbm_sat_counter #(
    parameter int CNT_W = 32,
    parameter int ADD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add_val,
    output logic [CNT_W-1:0] count
);

    localparam int SUM_W = ((CNT_W > ADD_W) ? CNT_W : ADD_W) + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'({CNT_W{1'b1}});

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] next_val;

    always_comb begin
        sum = SUM_W'(count) + SUM_W'(add_val);
        if (sum > TOP) begin
            next_val = {CNT_W{1'b1}};
        end else begin
            next_val = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (add_en) begin
            count <= next_val;
        end
    end

endmodule

// File: rtl/smem_bank_monitor.sv
module smem_bank_monitor
    import sbm_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int BANKS      = 32,
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 32,
    localparam int CYC_W     = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    req_valid,
    input  logic                    req_is_store,
    input  logic [LANES-1:0]        req_lane_mask,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    res_valid,
    output logic [CYC_W-1:0]        res_cycles,
    output logic                    res_is_store,
    input  logic [1:0]              rd_sel,
    output logic [CNT_W-1:0]        rd_data
);

    localparam int OFS_W   = $clog2(WORD_BYTES);
    localparam int BANK_W  = $clog2(BANKS);
    localparam int WADDR_W = ADDR_W - OFS_W;

    logic [LANES-1:0][WADDR_W-1:0] word_addr;
    logic [LANES-1:0][BANK_W-1:0]  lane_bank;
    logic [LANES-1:0]              lane_first;
    logic [CYC_W-1:0]              cyc_now;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign word_addr[i] = req_addr[i*ADDR_W+OFS_W +: WADDR_W];
        assign lane_bank[i] = word_addr[i][BANK_W-1:0];
    end

    sbm_word_dedup #(
        .LANES   (LANES),
        .WADDR_W (WADDR_W)
    ) dedup_i (
        .lane_mask  (req_lane_mask),
        .word_addr  (word_addr),
        .lane_first (lane_first)
    );

    sbm_bank_histogram #(
        .LANES  (LANES),
        .BANKS  (BANKS),
        .BANK_W (BANK_W),
        .CYC_W  (CYC_W)
    ) hist_i (
        .lane_first (lane_first),
        .lane_bank  (lane_bank),
        .max_depth  (cyc_now)
    );

    // Result stage state machine
    mon_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [CYC_W-1:0] cyc_q;
    logic             store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            store_q <= 1'b0;
        end else if (req_valid) begin
            cyc_q   <= cyc_now;
            store_q <= req_is_store;
        end
    end

    always_comb begin
        res_valid    = (state_q == ST_REPORT);
        res_cycles   = cyc_q;
        res_is_store = store_q;
    end

    // Profiling counters
    logic                              upd;
    logic [NUM_CNT-1:0]                add_en;
    logic [NUM_CNT-1:0][CYC_W-1:0]     add_val;
    logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_vals;

    always_comb begin
        upd = res_valid && (res_cycles != '0);
        add_en[SEL_REQS]     = upd;
        add_val[SEL_REQS]    = CYC_W'(1);
        add_en[SEL_CYCLES]   = upd;
        add_val[SEL_CYCLES]  = res_cycles;
        add_en[SEL_LD_CONF]  = upd && !res_is_store;
        add_val[SEL_LD_CONF] = res_cycles - CYC_W'(1);
        add_en[SEL_ST_CONF]  = upd && res_is_store;
        add_val[SEL_ST_CONF] = res_cycles - CYC_W'(1);
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        sbm_sat_counter #(
            .CNT_W (CNT_W),
            .ADD_W (CYC_W)
        ) cnt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .add_en  (add_en[k]),
            .add_val (add_val[k]),
            .count   (cnt_vals[k])
        );
    end

    always_comb begin
        unique case (cnt_sel_e'(rd_sel))
            SEL_REQS:    rd_data = cnt_vals[SEL_REQS];
            SEL_CYCLES:  rd_data = cnt_vals[SEL_CYCLES];
            SEL_LD_CONF: rd_data = cnt_vals[SEL_LD_CONF];
            SEL_ST_CONF: rd_data = cnt_vals[SEL_ST_CONF];
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
    parameter int LANES = 32,
    parameter int CNT_W = 32,
    parameter int CYC_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr,
    input logic                   req_valid,
    input logic [LANES-1:0]       req_lane_mask,
    input logic                   res_valid,
    input logic [CYC_W-1:0]       res_cycles,
    input logic                   res_is_store,
    input logic [3:0][CNT_W-1:0]  counters
);

    a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    a_r11_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_lane_mask == '0)) |=> (res_cycles == '0));

    a_r1_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ($countones(req_lane_mask) == 1)) |=> (res_cycles == CYC_W'(1)));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (counters == '0));

    a_r6_store_keeps_load: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_store && !clr) |=> $stable(counters[2]));

    a_r6_load_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_is_store && !clr) |=> $stable(counters[3]));

    for (genvar k = 0; k < 4; k++) begin : g_mono
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (counters[k] >= $past(counters[k])));
    end

endmodule

bind smem_bank_monitor sbm_checker #(
    .LANES (LANES),
    .CNT_W (CNT_W),
    .CYC_W (CYC_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .req_valid     (req_valid),
    .req_lane_mask (req_lane_mask),
    .res_valid     (res_valid),
    .res_cycles    (res_cycles),
    .res_is_store  (res_is_store),
    .counters      (cnt_vals)
);

// File: tb/smem_bank_monitor_tb_top.sv
`timescale 1ns/100ps
module smem_bank_monitor_tb_top;

    localparam int L     = 32;
    localparam int AW    = 16;
    localparam int CW    = 32;
    localparam int CWS   = 6;
    localparam int CYW   = $clog2(L + 1);
    localparam longint MAXB = (64'd1 << CW) - 1;
    localparam longint MAXS = (64'd1 << CWS) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_is_store = 1'b0;
    logic [L-1:0]   req_lane_mask = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic [1:0]     rd_sel = 2'd0;
    logic           res_valid, res_is_store;
    logic [CYW-1:0] res_cycles;
    logic [CW-1:0]  rd_data;
    logic           res_valid_s, res_is_store_s;
    logic [CYW-1:0] res_cycles_s;
    logic [CWS-1:0] rd_data_s;

    always #4 clk = ~clk;

    smem_bank_monitor #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid),
        .req_is_store(req_is_store), .req_lane_mask(req_lane_mask), .req_addr(req_addr),
        .res_valid(res_valid), .res_cycles(res_cycles), .res_is_store(res_is_store),
        .rd_sel(rd_sel), .rd_data(rd_data));

    smem_bank_monitor #(.CNT_W(CWS)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid),
        .req_is_store(req_is_store), .req_lane_mask(req_lane_mask), .req_addr(req_addr),
        .res_valid(res_valid_s), .res_cycles(res_cycles_s), .res_is_store(res_is_store_s),
        .rd_sel(rd_sel), .rd_data(rd_data_s));

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // new request, one-cycle-old, two-cycle-old
    bit n_v, n_st, n_clr; bit [L-1:0] n_m; bit [AW-1:0] n_a [L]; string n_tag; int n_cyc;
    bit p1_v, p1_st; int p1_cyc; string p1_tag;
    bit p2_v, p2_st; int p2_cyc;
    bit clr_prev;
    longint mb [4];
    longint ms [4];

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cycles(input bit [L-1:0] m, input bit [AW-1:0] a [L]);
        int best = 0;
        for (int b = 0; b < 32; b++) begin
            int n = 0;
            for (int i = 0; i < L; i++) begin
                if (m[i] && (((a[i] >> 2) % 32) == b)) begin
                    bit dup = 1'b0;
                    for (int j = 0; j < i; j++)
                        if (m[j] && ((a[j] >> 2) == (a[i] >> 2))) dup = 1'b1;
                    if (!dup) n++;
                end
            end
            if (n > best) best = n;
        end
        return best;
    endfunction

    function automatic longint sat(input longint x, input longint add, input longint mx);
        return (x + add > mx) ? mx : x + add;
    endfunction

    task automatic apply_model(input int cyc, input bit st);
        if (cyc > 0) begin
            mb[0] = sat(mb[0], 1, MAXB);      ms[0] = sat(ms[0], 1, MAXS);
            mb[1] = sat(mb[1], cyc, MAXB);    ms[1] = sat(ms[1], cyc, MAXS);
            if (st) begin
                mb[3] = sat(mb[3], cyc - 1, MAXB); ms[3] = sat(ms[3], cyc - 1, MAXS);
            end else begin
                mb[2] = sat(mb[2], cyc - 1, MAXB); ms[2] = sat(ms[2], cyc - 1, MAXS);
            end
        end
    endtask

    task automatic cycle();
        string ctag;
        @(negedge clk);
        if (clr_prev) begin
            for (int s = 0; s < 4; s++) begin mb[s] = 0; ms[s] = 0; end
        end else if (p2_v) begin
            apply_model(p2_cyc, p2_st);
        end
        check("R11", "res_valid", res_valid, p1_v);
        check("R11", "small res_valid", res_valid_s, p1_v);
        if (p1_v) begin
            check(p1_tag, "res_cycles", res_cycles, p1_cyc);
            check("R11", "res_is_store", res_is_store, p1_st);
        end
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.2;
            ctag = clr_prev ? "R8" : ((s < 2) ? "R5" : "R6");
            check(ctag, $sformatf("R9 counter sel %0d", s), rd_data, mb[s]);
            check("R7", $sformatf("narrow counter sel %0d", s), rd_data_s, ms[s]);
        end
        n_cyc = n_v ? exp_cycles(n_m, n_a) : 0;
        req_valid = n_v; req_is_store = n_st; req_lane_mask = n_m; clr = n_clr;
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = n_a[i];
        p2_v = p1_v; p2_st = p1_st; p2_cyc = p1_cyc;
        p1_v = n_v; p1_st = n_st; p1_cyc = n_cyc; p1_tag = n_tag;
        clr_prev = n_clr;
        n_clr = 1'b0;
    endtask

    task automatic set_stride(input int base, input int stride_w, input bit [L-1:0] m,
                              input bit st, input string tag);
        n_v = 1'b1; n_st = st; n_m = m; n_tag = tag;
        for (int i = 0; i < L; i++) n_a[i] = AW'((base + i * stride_w) * 4);
    endtask

    task automatic set_idle();
        n_v = 1'b0; n_st = 1'b0; n_m = '0; n_tag = "R11";
        for (int i = 0; i < L; i++) n_a[i] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd9157));
        for (int s = 0; s < 4; s++) begin mb[s] = 0; ms[s] = 0; end
        p1_v = 0; p2_v = 0; p1_st = 0; p2_st = 0; p1_cyc = 0; p2_cyc = 0; p1_tag = "R11";
        clr_prev = 0; n_clr = 0;
        set_idle();
        repeat (3) @(negedge clk);
        check("R10", "res_valid in reset", res_valid, 0);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); #0.2;
            check("R10", "counter in reset", rd_data, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        set_stride(5, 1, '1, 1'b0, "R4 seq");           cycle();
        set_stride(0, 2, '1, 1'b0, "R4 stride2");       cycle();
        set_stride(3, 32, '1, 1'b1, "R4 stride32");     cycle();
        set_stride(77, 0, '1, 1'b0, "R2 broadcast");    cycle();
        set_stride(0, 32, '0, 1'b1, "R3 empty");        cycle();
        set_stride(9, 32, 32'h0000_0100, 1'b1, "R1 single lane"); cycle();
        set_stride(0, 0, '1, 1'b1, "R2 merge");
        for (int i = 0; i < L; i++) n_a[i] = AW'((i % 4) * 128);
        cycle();
        set_stride(0, 0, '1, 1'b0, "R1 byte offsets");
        for (int i = 0; i < L; i++) n_a[i] = AW'((i / 4) * 4 + (i % 4));
        cycle();
        set_stride(0, 2, 32'h0000_ffff, 1'b0, "R1 half mask stride2"); cycle();
        set_idle(); cycle(); cycle();

        // clear with an increment due at the same edge
        set_stride(1, 32, '1, 1'b1, "R4 stride32 pre-clear"); cycle();
        set_stride(0, 1, '1, 1'b0, "R8 during clear"); n_clr = 1'b1; cycle();
        set_idle(); cycle(); cycle();

        // drive narrow counters into saturation
        for (int k = 0; k < 4; k++) begin
            set_stride(k, 32, '1, k[0], "R7 saturate"); cycle();
        end
        set_idle(); cycle(); cycle();

        // constrained random stream
        for (int t = 0; t < 3000; t++) begin
            int kind = $urandom % 7;
            bit [L-1:0] m = ($urandom % 3 == 0) ? L'($urandom) : '1;
            bit st = $urandom % 2;
            case (kind)
                0: set_stride($urandom % 4096, 1, m, st, "R11 rand seq");
                1: set_stride($urandom % 4096, 1 + $urandom % 40, m, st, "R11 rand stride");
                2: set_stride($urandom % 4096, 0, m, st, "R2 rand broadcast");
                3: begin
                    set_stride(0, 0, m, st, "R1 rand addr");
                    for (int i = 0; i < L; i++) n_a[i] = AW'($urandom);
                end
                4: begin
                    set_stride(0, 0, m, st, "R2 rand dense");
                    for (int i = 0; i < L; i++) n_a[i] = AW'($urandom % 512);
                end
                5: set_stride(0, 32, '0, st, "R3 rand empty");
                default: set_idle();
            endcase
            if ($urandom % 60 == 0) n_clr = 1'b1;
            cycle();
        end
        set_idle(); cycle(); cycle(); cycle();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule